// File: doc/BRIEF.md
# Synchronous Burst SRAM with Byte Lanes

This block is a behavioural-synthesizable model of a synchronous static RAM that has a two-bit burst sequencer in front of it. Address, chip selects, address strobes, the advance input and all write controls are captured on the rising clock edge. A captured strobe starts an access at the presented address. Later cycles without a strobe continue the same burst, and the advance input steps the low two address bits in either linear or interleaved order. Writes either fill selected byte lanes or, through the global write input, fill the whole word. Write data is taken at the same edge as the command.

Read data reaches the output in one of two ways, picked by a static strap. In flow-through mode it comes straight from the array, which gives 2-1-1-1 bursts. In pipelined mode it passes through an output register, which gives 3-1-1-1 bursts. The bidirectional data bus is split into an input bus, an output bus and a drive flag. The drive flag is gated without any clock by the active-low output enable and by the active-high sleep input. While sleep is high, no state changes and the array keeps its contents.

Top module: `sync_burst_sram`

## Requirements
- R1: An access starts only when a strobe (`adsp_n` or `adsc_n` low) is captured while `ce1_n`=0, `ce2`=1 and `ce3_n`=0. A strobe captured with any enable false is a deselect: nothing is written, the burst ends, and `adv_n` alone starts nothing.
- R2: With `gw_n`=0, an access writes all four 9-bit lanes from `din`, whatever `bwe_n` and `lane_n` are.
- R3: With `gw_n`=1 and `bwe_n`=0, only the lanes whose `lane_n[i]`=0 are written, where lane i is bit field [9i+8:9i]. When no lane is selected, the access is a read. A cycle that writes returns no read data.
- R4: Each beat of a write burst takes `din` from the same clock edge that captures that beat.
- R5: Beat n of a burst uses the base address with its low two bits replaced. With `linear_n`=0 they become (base+n) mod 4; with `linear_n`=1 they become base XOR n. The upper bits are unchanged. A continuation cycle with `adv_n`=1 repeats the current address.
- R6: With `pipe_sel`=0, a read captured at edge k drives its data from just after edge k until edge k+1.
- R7: With `pipe_sel`=1, a read captured at edge k drives its data from just after edge k+1. A write captured at edge k+1 to the same address does not change that data.
- R8: `oe_n`=1 forces `dout_drive`=0 and `dout`=0 immediately, without a clock edge. Reads still proceed, and their data shows as soon as `oe_n` returns to 0.
- R9: `sleep`=1 removes the drive at once, blocks writes and freezes the burst state. After release the burst resumes where it stopped, and the stored data is unchanged.
- R10: After a deselect is captured at edge k, the drive is off from edge k in flow-through mode. In pipelined mode it is off from edge k+1, after the last beat has been driven.
- R11: After reset, `dout_drive` is 0 and no burst is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of control state |
| addr | input | ADDR_W | Word address |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| adsp_n | input | 1 | Address strobe, active low |
| adsc_n | input | 1 | Address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte write, active low |
| lane_n | input | LANES | Per-lane write enables, active low |
| din | input | DATA_W | Write data |
| pipe_sel | input | 1 | Strap: 1 pipelined, 0 flow-through |
| linear_n | input | 1 | Strap: 0 linear, 1 interleaved order |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Asynchronous sleep, active high |
| dout | output | DATA_W | Read data, zero when not driven |
| dout_drive | output | 1 | Output bus is driven |

## Verification
In pipelined mode the output register is still presenting a read beat when the next command, a write to that same word, is captured. The array update and the register load therefore fall on the same edge. The bench reads a word and writes new data to it on the very next edge. It expects the old word on the bus after that edge, no drive one cycle later, and the new word when the address is read again. The sleep input is also raised in the middle of a burst while write commands are presented, and the bench checks that the burst resumes at the held beat.

// File: rtl/sync_burst_sram.sv
`timescale 1ns/1ps
module sync_burst_sram #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  parameter int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ce1_n,
  input  logic              ce2,
  input  logic              ce3_n,
  input  logic              adsp_n,
  input  logic              adsc_n,
  input  logic              adv_n,
  input  logic              gw_n,
  input  logic              bwe_n,
  input  logic [LANES-1:0]  lane_n,
  input  logic [DATA_W-1:0] din,
  input  logic              pipe_sel,
  input  logic              linear_n,
  input  logic              oe_n,
  input  logic              sleep,
  output logic [DATA_W-1:0] dout,
  output logic              dout_drive
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  logic              act_q, rd_q, pvld_q;
  logic [1:0]        cnt_q;
  logic [ADDR_W-1:0] base_q, rd_addr_q;
  logic [DATA_W-1:0] pipe_q;

  logic              strobe, selected, acc, act_nx;
  logic [1:0]        cnt_nx;
  logic [ADDR_W-1:0] base_nx, acc_addr;
  logic [LANES-1:0]  lane_mask;
  logic              do_wr, do_rd;

  function automatic logic [ADDR_W-1:0] beat_addr(input logic [ADDR_W-1:0] b,
                                                 input logic [1:0] c,
                                                 input logic lin_n);
    beat_addr = b;
    beat_addr[1:0] = lin_n ? (b[1:0] ^ c) : (b[1:0] + c);
  endfunction

  assign strobe   = !adsp_n || !adsc_n;
  assign selected = !ce1_n && ce2 && !ce3_n;

  always_comb begin
    act_nx  = act_q;
    base_nx = base_q;
    cnt_nx  = cnt_q;
    acc     = 1'b0;
    if (strobe) begin
      act_nx = selected;
      acc    = selected;
      if (selected) begin
        base_nx = addr;
        cnt_nx  = 2'd0;
      end
    end else if (act_q) begin
      acc = 1'b1;
      if (!adv_n) cnt_nx = cnt_q + 2'd1;
    end
  end

  assign acc_addr  = beat_addr(base_nx, cnt_nx, linear_n);
  assign lane_mask = !gw_n ? '1 : (!bwe_n ? ~lane_n : '0);
  assign do_wr     = acc && (|lane_mask) && !sleep;
  assign do_rd     = acc && !(|lane_mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q     <= 1'b0;
      base_q    <= '0;
      cnt_q     <= '0;
      rd_q      <= 1'b0;
      rd_addr_q <= '0;
      pvld_q    <= 1'b0;
      pipe_q    <= '0;
    end else if (!sleep) begin
      act_q     <= act_nx;
      base_q    <= base_nx;
      cnt_q     <= cnt_nx;
      rd_q      <= do_rd;
      rd_addr_q <= acc_addr;
      pvld_q    <= rd_q;
      pipe_q    <= mem[rd_addr_q];
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) begin
      for (int l = 0; l < LANES; l++) begin
        if (lane_mask[l]) mem[acc_addr][l*LANE_W +: LANE_W] <= din[l*LANE_W +: LANE_W];
      end
    end
  end

  assign dout_drive = (pipe_sel ? pvld_q : rd_q) && !oe_n && !sleep;
  assign dout       = dout_drive ? (pipe_sel ? pipe_q : mem[rd_addr_q]) : '0;
endmodule

// File: rtl/sram_checks.sv
`timescale 1ns/1ps
module sram_checks #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sleep,
  input logic              oe_n,
  input logic              pipe_sel,
  input logic              gw_n,
  input logic              strobe,
  input logic              selected,
  input logic              act_q,
  input logic [1:0]        cnt_q,
  input logic [ADDR_W-1:0] base_q,
  input logic              dout_drive
);
  logic dsel;
  assign dsel = !sleep && strobe && !selected;

  a_r1_deselect_ends_burst: assert property (@(posedge clk) disable iff (!rst_n)
    dsel |=> !act_q);

  a_r3_write_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && strobe && selected && !gw_n && !pipe_sel) |=> !dout_drive);

  a_r8_oe_blocks_drive: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dout_drive);

  a_r9_sleep_blocks_drive: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> !dout_drive);

  a_r9_sleep_holds_burst: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep && $past(sleep)) |-> ($stable(cnt_q) && $stable(act_q) && $stable(base_q)));

  a_r10_flow_release: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(dsel) && !pipe_sel && !$past(pipe_sel)) |-> !dout_drive);

  a_r10_pipe_release: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(dsel, 2) && !$past(sleep) && pipe_sel && $past(pipe_sel, 2)) |-> !dout_drive);
endmodule

bind sync_burst_sram sram_checks #(.ADDR_W(ADDR_W)) u_sram_checks (
  .clk(clk), .rst_n(rst_n), .sleep(sleep), .oe_n(oe_n), .pipe_sel(pipe_sel),
  .gw_n(gw_n), .strobe(strobe), .selected(selected), .act_q(act_q),
  .cnt_q(cnt_q), .base_q(base_q), .dout_drive(dout_drive)
);

// File: tb/test_sync_burst_sram.sv
`timescale 1ns/1ps
module test_sync_burst_sram;
  localparam int AW = 8;
  localparam int DW = 36;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n, ce1_n, ce2, ce3_n, adsp_n, adsc_n, adv_n, gw_n, bwe_n;
  logic          pipe_sel, linear_n, oe_n, sleep, dout_drive;
  logic [AW-1:0] addr;
  logic [3:0]    lane_n;
  logic [DW-1:0] din, dout;

  logic [DW-1:0] refm [256];
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  sync_burst_sram #(.ADDR_W(AW), .LANES(4), .LANE_W(9)) i_sync_burst_sram (
    .clk(clk), .rst_n(rst_n), .addr(addr), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
    .adsp_n(adsp_n), .adsc_n(adsc_n), .adv_n(adv_n), .gw_n(gw_n), .bwe_n(bwe_n),
    .lane_n(lane_n), .din(din), .pipe_sel(pipe_sel), .linear_n(linear_n),
    .oe_n(oe_n), .sleep(sleep), .dout(dout), .dout_drive(dout_drive)
  );

  task automatic chk(input string req, input string what, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic idle_in();
    ce1_n = 0; ce2 = 1; ce3_n = 0; adsp_n = 1; adsc_n = 1; adv_n = 1;
    gw_n = 1; bwe_n = 1; lane_n = 4'hF; din = '0; oe_n = 0; sleep = 0;
  endtask

  task automatic desel();
    adsc_n = 0; adsp_n = 1; ce1_n = 1; adv_n = 1; gw_n = 1; bwe_n = 1; lane_n = 4'hF;
    step();
    ce1_n = 0; adsc_n = 1;
    step();
  endtask

  function automatic logic [DW-1:0] pat(input int a);
    return {4'(a), 8'(a * 7 + 1), 8'(~a), 8'(a ^ 8'h3C), 8'(a + 91)};
  endfunction

  function automatic logic [AW-1:0] baddr(input logic [AW-1:0] b, input int j, input bit lin);
    logic [AW-1:0] r = b;
    r[1:0] = lin ? 2'(b[1:0] + 2'(j)) : (b[1:0] ^ 2'(j));
    return r;
  endfunction

  task automatic read_single(input logic [AW-1:0] a, input string req);
    pipe_sel = 0; adsc_n = 0; addr = a;
    step();
    chk(req, "single read drive", dout_drive, 1);
    chk(req, "single read data", dout, refm[a]);
    adsc_n = 1;
    desel();
  endtask

  task automatic t_reset();
    chk("R11", "drive after reset", dout_drive, 0);
    adv_n = 0;
    step();
    chk("R11", "advance with no burst", dout_drive, 0);
    adv_n = 1;
  endtask

  task automatic t_fill();
    pipe_sel = 0;
    for (int a = 0; a < 256; a++) begin
      adsc_n = 0; addr = AW'(a); gw_n = 0; din = pat(a);
      step();
      refm[a] = pat(a);
    end
    desel();
  endtask

  task automatic t_burst_read(input logic [AW-1:0] b, input bit lin, input bit pp);
    logic [DW-1:0] d [6];
    logic v [6];
    string r = pp ? "R7" : "R6";
    pipe_sel = pp; linear_n = !lin;
    for (int j = 0; j < 6; j++) begin
      if (j == 0) begin adsc_n = 0; addr = b; end
      else if (j < 4) begin adsc_n = 1; adv_n = 0; end
      else if (j == 4) begin adsc_n = 0; ce1_n = 1; adv_n = 1; end
      else begin adsc_n = 1; ce1_n = 0; end
      step();
      d[j] = dout; v[j] = dout_drive;
    end
    if (pp) chk("R7", "no data before third edge", v[0], 0);
    for (int j = 0; j < 4; j++) begin
      int k = pp ? j + 1 : j;
      chk(r, $sformatf("beat %0d drive", j), v[k], 1);
      chk({r, "/R5"}, $sformatf("beat %0d data base %h", j, b), d[k], refm[baddr(b, j, lin)]);
    end
    chk("R10", "released after deselect", v[pp ? 5 : 4], 0);
  endtask

  task automatic t_burst_write(input logic [AW-1:0] b, input bit lin);
    pipe_sel = 0; linear_n = !lin; gw_n = 0;
    for (int j = 0; j < 4; j++) begin
      logic [DW-1:0] wd = {4'(j), 24'hC0FFEE, b};
      if (j == 0) begin adsc_n = 0; addr = b; end
      else begin adsc_n = 1; adv_n = 0; end
      din = wd;
      step();
      chk("R3", "write beat not driven", dout_drive, 0);
      refm[baddr(b, j, lin)] = wd;
    end
    desel();
    t_burst_read(b, lin, 1'b1);
  endtask

  task automatic t_byte_write();
    logic [AW-1:0] a = 8'h61;
    pipe_sel = 0;
    adsc_n = 0; addr = a; gw_n = 1; bwe_n = 0; lane_n = 4'b1010; din = 36'h1_2345_6789;
    step();
    for (int l = 0; l < 4; l++) if (!lane_n[l]) refm[a][l*9 +: 9] = din[l*9 +: 9];
    adsc_n = 1;
    desel();
    read_single(a, "R3");
    adsc_n = 0; addr = a; gw_n = 1; bwe_n = 1; lane_n = 4'h0; din = 36'hA_AAAA_AAAA;
    step();
    chk("R3", "byte write off is read drive", dout_drive, 1);
    chk("R3", "byte write off data", dout, refm[a]);
    bwe_n = 0; lane_n = 4'hF;
    step();
    chk("R3", "no lane selected is read drive", dout_drive, 1);
    chk("R3", "no lane selected data", dout, refm[a]);
    gw_n = 0; bwe_n = 0; lane_n = 4'hF; din = 36'hF_0F0F_0F0F;
    step();
    refm[a] = din;
    chk("R2", "global write not driven", dout_drive, 0);
    desel();
    read_single(a, "R2");
  endtask

  task automatic t_suspend();
    logic [AW-1:0] b = 8'h21;
    int seq [5] = '{0, 0, 1, 1, 2};
    pipe_sel = 0; linear_n = 0;
    for (int j = 0; j < 5; j++) begin
      if (j == 0) begin adsp_n = 0; addr = b; end
      else begin adsp_n = 1; adv_n = (j == 1 || j == 3); end
      step();
      chk("R5", $sformatf("suspend step %0d", j), dout, refm[baddr(b, seq[j], 1)]);
    end
    desel();
  endtask

  task automatic t_oe();
    pipe_sel = 0; adsc_n = 0; addr = 8'h77;
    step();
    adsc_n = 1;
    chk("R8", "flow drive", dout_drive, 1);
    oe_n = 1; #1;
    chk("R8", "oe high drive", dout_drive, 0);
    chk("R8", "oe high data", dout, 0);
    oe_n = 0; #1;
    chk("R8", "oe low again", dout, refm[8'h77]);
    desel();
    pipe_sel = 1; oe_n = 1; adsc_n = 0; addr = 8'h78;
    step();
    adsc_n = 1;
    step();
    chk("R8", "pipe read hidden", dout_drive, 0);
    oe_n = 0; #1;
    chk("R8", "pipe read shows", dout, refm[8'h78]);
    desel();
  endtask

  task automatic t_sleep();
    pipe_sel = 0; linear_n = 0; adsc_n = 0; addr = 8'h40;
    step();
    chk("R9", "beat before sleep", dout, refm[8'h40]);
    sleep = 1; #1;
    chk("R9", "sleep drops drive", dout_drive, 0);
    gw_n = 0; adsc_n = 0; addr = 8'h80; din = 36'h5_5555_5555;
    for (int j = 0; j < 2; j++) begin
      step();
      chk("R9", "no drive while asleep", dout_drive, 0);
    end
    gw_n = 1; adsc_n = 1; adv_n = 1; sleep = 0; #1;
    chk("R9", "held beat after wake", dout, refm[8'h40]);
    adv_n = 0;
    step();
    chk("R9", "burst resumes", dout, refm[8'h41]);
    desel();
    read_single(8'h80, "R9");
  endtask

  task automatic t_overlap();
    logic [AW-1:0] a = 8'h55;
    logic [DW-1:0] old = refm[a];
    pipe_sel = 1; adsc_n = 0; addr = a; gw_n = 1;
    step();
    gw_n = 0; din = 36'h3_1415_9265;
    step();
    chk("R7", "read beat beside write drive", dout_drive, 1);
    chk("R7", "read beat keeps old word", dout, old);
    refm[a] = din;
    gw_n = 1; adsc_n = 1;
    step();
    chk("R3", "write slot gives no beat", dout_drive, 0);
    desel();
    read_single(a, "R4");
  endtask

  task automatic t_select();
    for (int i = 0; i < 3; i++) begin
      logic [AW-1:0] a = AW'(8'h90 + i);
      ce1_n = (i == 0); ce2 = (i != 1); ce3_n = (i == 2);
      adsc_n = 0; addr = a; gw_n = 0; din = 36'hE_EEEE_EEEE;
      step();
      chk("R1", $sformatf("enable %0d off no drive", i), dout_drive, 0);
      ce1_n = 0; ce2 = 1; ce3_n = 0; gw_n = 1; adsc_n = 1; adv_n = 0;
      step();
      chk("R1", "advance after deselect", dout_drive, 0);
      adv_n = 1;
      read_single(a, "R1");
    end
  endtask

  initial begin
    idle_in();
    rst_n = 0; pipe_sel = 0; linear_n = 0; addr = '0;
    repeat (3) step();
    rst_n = 1;
    step();
    t_reset();
    t_fill();
    t_burst_read(8'h10, 1, 0);
    t_burst_read(8'h13, 1, 1);
    t_burst_read(8'h26, 0, 0);
    t_burst_read(8'h2B, 0, 1);
    t_burst_write(8'h34, 0);
    t_burst_write(8'h4B, 1);
    t_byte_write();
    t_suspend();
    t_oe();
    t_sleep();
    t_overlap();
    t_select();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule